// File: doc/BRIEF.md
# ATM Cell Receive Disposition Sequencer

This block sits behind a byte-wide receive FIFO and decides what happens to each ATM cell that comes out of it. Each cell arrives as a leading header-status byte, zero or more payload bytes, and a trailing CRC-10 status byte. A ninth bit on the FIFO marks the final byte of the cell. Cells whose header status reads good are forwarded byte by byte on a data-valid strobe, after a single lookup-launch request. Idle cells and cells with a corrupt header checksum are popped and discarded.

For a forwarded cell, the trailing byte is kept as the CRC indication. A fixed run of idle cycles then lets downstream writes settle. After that, a one-cycle completion pulse presents the header status and the CRC indication together. When several receive engines share a concatenated line, the block pulses a shared ownership token for one clock once it has handled the header of a non-idle cell. On a non-concatenated line the token output stays low.

Top module: `atm_rx_sequencer`

## Requirements
- R1: After reset, and while the FIFO is empty, the block drives low on fifoPop, outValid, lookupReq, tokenOut and donePulse, and drives zero on doneStatus and doneCrc.
- R2: A cell whose header byte is neither 0x01 (idle) nor 0x80 (bad header checksum) counts as good. 0x00 is the normal good code. A good cell produces exactly one single-cycle lookupReq pulse, and this pulse comes before the first outValid of that cell.
- R3: For a good cell, every byte after the header whose ninth bit is clear is presented on outData with outValid high for one cycle. This happens one cycle after the byte is popped, and the bytes appear in FIFO order. The byte with the ninth bit set is not forwarded.
- R4: On donePulse, doneStatus equals the header byte of the cell and doneCrc equals that cell's ninth-bit byte.
- R5: donePulse is high for exactly one cycle, per good cell. When the FIFO never runs empty, it rises STALL_CYCLES+1 cycles after the cycle of the final outValid.
- R6: An idle cell (header 0x01) is popped through its ninth-bit byte with no outValid, no lookupReq, no tokenOut and no donePulse. The cell after it is then handled normally.
- R7: A bad cell (header 0x80) is popped through its ninth-bit byte with no outValid, no lookupReq and no donePulse.
- R8: With concatMode high, tokenOut is high for exactly one cycle for each good or bad cell, and never for an idle cell. For a good cell, this cycle immediately precedes the lookupReq cycle.
- R9: With concatMode low, tokenOut stays low.
- R10: fifoPop is never asserted while fifoEmpty is high. An empty FIFO halts the sequence without losing or repeating bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| concatMode | input | 1 | High when the line is shared by concatenated engines |
| fifoData | input | 8 | Byte at the FIFO head |
| fifoLast | input | 1 | Ninth bit: head byte ends the cell |
| fifoEmpty | input | 1 | FIFO has no byte |
| fifoPop | output | 1 | Consume the head byte this cycle |
| outData | output | 8 | Forwarded payload byte |
| outValid | output | 1 | outData holds a payload byte |
| lookupReq | output | 1 | One-cycle lookup launch request |
| tokenOut | output | 1 | One-cycle ownership token hand-off |
| donePulse | output | 1 | One-cycle completion strobe |
| doneStatus | output | 8 | Header status of the completed cell |
| doneCrc | output | 8 | CRC-10 indication of the completed cell |

## Verification
If the control state slips, the effect shows at the ports within one or two cycles of the affected byte. A misread header sends a dropped cell onto outValid, or makes a good cell silent, at the first payload pop. A wrong drain exit shows up as a corrupted next cell. An error in the stall counter moves donePulse away from the fixed distance after the last outValid. A token placed in the wrong spot shows as a missing, doubled or misaligned pulse next to lookupReq.

// File: rtl/atm_rx_pkg.sv
package atm_rx_pkg;
  localparam logic [7:0] HDR_IDLE = 8'h01;
  localparam logic [7:0] HDR_BAD  = 8'h80;

  typedef enum logic [2:0] {
    ST_WAIT_HDR,
    ST_TOKEN,
    ST_LAUNCH,
    ST_PAYLOAD,
    ST_STALL,
    ST_DONE,
    ST_DRAIN
  } seqState_t;

  typedef struct packed {
    logic capHdr;
    logic fwdByte;
    logic capCrc;
  } ctlStrobes_t;
endpackage

// File: rtl/atm_rx_ctrl.sv
module atm_rx_ctrl
  import atm_rx_pkg::*;
#(
  parameter int STALL_CYCLES = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        concatMode,
  input  logic        fifoLast,
  input  logic        fifoEmpty,
  input  logic        headIsIdle,
  input  logic        headIsBad,
  input  logic        savedBad,
  output logic        fifoPop,
  output logic        lookupReq,
  output logic        tokenOut,
  output logic        donePulse,
  output ctlStrobes_t stb
);
  localparam int CNT_W = $clog2(STALL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(STALL_CYCLES - 1);

  seqState_t state, nextState;
  logic [CNT_W-1:0] stallCnt;

  always_comb begin
    nextState = state;
    fifoPop   = 1'b0;
    lookupReq = 1'b0;
    tokenOut  = 1'b0;
    donePulse = 1'b0;
    stb       = '0;
    case (state)
      ST_WAIT_HDR: if (!fifoEmpty) begin
        fifoPop    = 1'b1;
        stb.capHdr = 1'b1;
        if (headIsIdle)     nextState = ST_DRAIN;
        else if (concatMode) nextState = ST_TOKEN;
        else if (headIsBad) nextState = ST_DRAIN;
        else                nextState = ST_LAUNCH;
      end
      ST_TOKEN: begin
        tokenOut  = 1'b1;
        nextState = savedBad ? ST_DRAIN : ST_LAUNCH;
      end
      ST_LAUNCH: begin
        lookupReq = 1'b1;
        nextState = ST_PAYLOAD;
      end
      ST_PAYLOAD: if (!fifoEmpty) begin
        fifoPop = 1'b1;
        if (fifoLast) begin
          stb.capCrc = 1'b1;
          nextState  = ST_STALL;
        end else begin
          stb.fwdByte = 1'b1;
        end
      end
      ST_STALL: if (stallCnt == CNT_END) nextState = ST_DONE;
      ST_DONE: begin
        donePulse = 1'b1;
        nextState = ST_WAIT_HDR;
      end
      ST_DRAIN: if (!fifoEmpty) begin
        fifoPop = 1'b1;
        if (fifoLast) nextState = ST_WAIT_HDR;
      end
      default: nextState = ST_WAIT_HDR;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_WAIT_HDR;
      stallCnt <= '0;
    end else begin
      state    <= nextState;
      stallCnt <= (state == ST_STALL) ? stallCnt + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/atm_rx_datapath.sv
module atm_rx_datapath
  import atm_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] fifoData,
  input  ctlStrobes_t       stb,
  output logic              headIsIdle,
  output logic              headIsBad,
  output logic              savedBad,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic [DATA_W-1:0] doneStatus,
  output logic [DATA_W-1:0] doneCrc
);
  logic [DATA_W-1:0] hdrReg, crcReg;

  assign headIsIdle = (fifoData == DATA_W'(HDR_IDLE));
  assign headIsBad  = (fifoData == DATA_W'(HDR_BAD));
  assign savedBad   = (hdrReg == DATA_W'(HDR_BAD));
  assign doneStatus = hdrReg;
  assign doneCrc    = crcReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrReg   <= '0;
      crcReg   <= '0;
      outData  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= stb.fwdByte;
      if (stb.fwdByte) outData <= fifoData;
      if (stb.capHdr)  hdrReg  <= fifoData;
      if (stb.capCrc)  crcReg  <= fifoData;
    end
  end
endmodule

// File: rtl/atm_rx_sequencer.sv
module atm_rx_sequencer
  import atm_rx_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int STALL_CYCLES = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              concatMode,
  input  logic [DATA_W-1:0] fifoData,
  input  logic              fifoLast,
  input  logic              fifoEmpty,
  output logic              fifoPop,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              lookupReq,
  output logic              tokenOut,
  output logic              donePulse,
  output logic [DATA_W-1:0] doneStatus,
  output logic [DATA_W-1:0] doneCrc
);
  ctlStrobes_t stb;
  logic headIsIdle, headIsBad, savedBad;

  atm_rx_ctrl #(.STALL_CYCLES(STALL_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .concatMode(concatMode), .fifoLast(fifoLast),
    .fifoEmpty(fifoEmpty), .headIsIdle(headIsIdle), .headIsBad(headIsBad),
    .savedBad(savedBad), .fifoPop(fifoPop), .lookupReq(lookupReq),
    .tokenOut(tokenOut), .donePulse(donePulse), .stb(stb)
  );

  atm_rx_datapath #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .fifoData(fifoData), .stb(stb),
    .headIsIdle(headIsIdle), .headIsBad(headIsBad), .savedBad(savedBad),
    .outData(outData), .outValid(outValid),
    .doneStatus(doneStatus), .doneCrc(doneCrc)
  );
endmodule

// File: rtl/atm_rx_sequencer_chk.sv
module atm_rx_sequencer_chk (
  input logic clk,
  input logic rstN,
  input logic concatMode,
  input logic fifoEmpty,
  input logic fifoPop,
  input logic outValid,
  input logic lookupReq,
  input logic tokenOut,
  input logic donePulse
);
  a_r10_no_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> !fifoEmpty);
  a_r8_token_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    tokenOut |=> !tokenOut);
  a_r9_no_token_plain: assert property (@(posedge clk) disable iff (!rstN)
    !concatMode |-> !tokenOut);
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);
  a_r2_lookup_single: assert property (@(posedge clk) disable iff (!rstN)
    lookupReq |=> !lookupReq);
  a_r2_lookup_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    lookupReq |-> !outValid);
  a_r3_no_valid_at_done: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> !outValid);
endmodule

bind atm_rx_sequencer atm_rx_sequencer_chk uChk (
  .clk(clk), .rstN(rstN), .concatMode(concatMode), .fifoEmpty(fifoEmpty),
  .fifoPop(fifoPop), .outValid(outValid), .lookupReq(lookupReq),
  .tokenOut(tokenOut), .donePulse(donePulse)
);

// File: tb/tb_atm_rx_sequencer.sv
module tb_atm_rx_sequencer;
  localparam int STALL = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic concatMode = 1'b0;
  logic [7:0] fifoData;
  logic fifoLast, fifoEmpty, fifoPop;
  logic [7:0] outData, doneStatus, doneCrc;
  logic outValid, lookupReq, tokenOut, donePulse;

  always #5 clk = ~clk;

  logic [8:0] mem [0:1023];
  logic [9:0] rdPtr = '0;
  logic [9:0] wrPtr = '0;
  assign fifoEmpty = (rdPtr == wrPtr);
  assign fifoData  = mem[rdPtr][7:0];
  assign fifoLast  = mem[rdPtr][8];

  atm_rx_sequencer #(.DATA_W(8), .STALL_CYCLES(STALL)) dut (
    .clk(clk), .rstN(rstN), .concatMode(concatMode), .fifoData(fifoData),
    .fifoLast(fifoLast), .fifoEmpty(fifoEmpty), .fifoPop(fifoPop),
    .outData(outData), .outValid(outValid), .lookupReq(lookupReq),
    .tokenOut(tokenOut), .donePulse(donePulse), .doneStatus(doneStatus),
    .doneCrc(doneCrc)
  );

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rstN && fifoPop && !fifoEmpty) rdPtr <= rdPtr + 1'b1;
  end

  int checks = 0, failures = 0;
  logic [7:0] rxQ[$];
  int lookupCnt, tokenCnt, doneCnt, badPops;
  int lookupCyc, tokenCyc, doneCyc, firstValidCyc, lastValidCyc;
  logic [7:0] doneSt, doneCr;

  always @(negedge clk) begin
    if (rstN) begin
      if (outValid) begin
        rxQ.push_back(outData);
        if (firstValidCyc < 0) firstValidCyc = cyc;
        lastValidCyc = cyc;
      end
      if (lookupReq) begin lookupCnt++; lookupCyc = cyc; end
      if (tokenOut)  begin tokenCnt++;  tokenCyc  = cyc; end
      if (donePulse) begin doneCnt++; doneCyc = cyc; doneSt = doneStatus; doneCr = doneCrc; end
      if (fifoPop && fifoEmpty) badPops++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearStats();
    rxQ.delete();
    lookupCnt = 0; tokenCnt = 0; doneCnt = 0; badPops = 0;
    lookupCyc = -1; tokenCyc = -1; doneCyc = -1; firstValidCyc = -1; lastValidCyc = -1;
    doneSt = '0; doneCr = '0;
  endtask

  task automatic pushByte(input logic [7:0] d, input logic last);
    mem[wrPtr] = {last, d};
    wrPtr = wrPtr + 1'b1;
  endtask

  task automatic pushBody(input int n, input logic [7:0] base, input logic [7:0] crc);
    for (int i = 0; i < n; i++) pushByte(base + 8'(i), 1'b0);
    pushByte(crc, 1'b1);
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkPayload(input int n, input logic [7:0] base, input string req);
    check(rxQ.size() == n, req, rxQ.size(), n);
    for (int i = 0; i < n && i < rxQ.size(); i++)
      check(rxQ[i] == base + 8'(i), req, rxQ[i], base + 8'(i));
  endtask

  task automatic testReset();
    waitCycles(3);
    check(fifoPop == 0 && outValid == 0 && lookupReq == 0, "R1 pop/valid/lookup", {fifoPop, outValid, lookupReq}, 0);
    check(tokenOut == 0 && donePulse == 0, "R1 token/done", {tokenOut, donePulse}, 0);
    check(doneStatus == 0 && doneCrc == 0, "R1 status/crc", {doneStatus, doneCrc}, 0);
  endtask

  task automatic testGood(input logic [7:0] hdr, input int n, input logic [7:0] base,
                          input logic [7:0] crc, input logic concat, input string req);
    @(negedge clk); concatMode = concat; clearStats();
    pushByte(hdr, 1'b0); pushBody(n, base, crc);
    waitCycles(n + STALL + 20);
    checkPayload(n, base, {req, " R3 payload"});
    check(lookupCnt == 1, {req, " R2 lookup count"}, lookupCnt, 1);
    if (n > 0) check(lookupCyc < firstValidCyc, {req, " R2 lookup first"}, lookupCyc, firstValidCyc);
    check(doneCnt == 1, {req, " R5 done count"}, doneCnt, 1);
    check(doneSt == hdr, {req, " R4 status"}, doneSt, hdr);
    check(doneCr == crc, {req, " R4 crc"}, doneCr, crc);
    if (n > 0) check(doneCyc - lastValidCyc == STALL + 1, {req, " R5 stall"}, doneCyc - lastValidCyc, STALL + 1);
    if (concat) begin
      check(tokenCnt == 1, {req, " R8 token count"}, tokenCnt, 1);
      check(lookupCyc - tokenCyc == 1, {req, " R8 token before lookup"}, lookupCyc - tokenCyc, 1);
    end else begin
      check(tokenCnt == 0, {req, " R9 no token"}, tokenCnt, 0);
    end
  endtask

  task automatic testDrop(input logic [7:0] hdr, input int n, input logic concat, input string req);
    @(negedge clk); concatMode = concat; clearStats();
    pushByte(hdr, 1'b0); pushBody(n, 8'h40, 8'hEE);
    waitCycles(n + STALL + 20);
    check(rxQ.size() == 0, {req, " no valid"}, rxQ.size(), 0);
    check(lookupCnt == 0, {req, " no lookup"}, lookupCnt, 0);
    check(doneCnt == 0, {req, " no done"}, doneCnt, 0);
    check(rdPtr == wrPtr, {req, " drained"}, rdPtr, wrPtr);
    check(tokenCnt == ((concat && hdr == 8'h80) ? 1 : 0), {req, " R8 token"}, tokenCnt,
          (concat && hdr == 8'h80) ? 1 : 0);
  endtask

  task automatic testGap();
    @(negedge clk); concatMode = 1'b0; clearStats();
    pushByte(8'h00, 1'b0);
    for (int i = 0; i < 3; i++) pushByte(8'h90 + 8'(i), 1'b0);
    waitCycles(25);
    check(rxQ.size() == 3, "R10 partial bytes", rxQ.size(), 3);
    check(doneCnt == 0, "R10 waits while empty", doneCnt, 0);
    for (int i = 3; i < 6; i++) pushByte(8'h90 + 8'(i), 1'b0);
    pushByte(8'h5A, 1'b1);
    waitCycles(STALL + 20);
    checkPayload(6, 8'h90, "R10 payload after gap");
    check(doneCnt == 1 && doneCr == 8'h5A, "R10 done after gap", doneCr, 8'h5A);
    check(badPops == 0, "R10 no pop while empty", badPops, 0);
  endtask

  task automatic testBackToBack();
    @(negedge clk); concatMode = 1'b0; clearStats();
    pushByte(8'h01, 1'b0); pushBody(4, 8'h70, 8'h11);
    pushByte(8'h00, 1'b0); pushBody(5, 8'hA0, 8'h22);
    waitCycles(STALL + 40);
    checkPayload(5, 8'hA0, "R6 cell after idle");
    check(doneCnt == 1 && doneCr == 8'h22, "R6 next cell done", doneCr, 8'h22);
  endtask

  initial begin
    clearStats();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testGood(8'h00, 8, 8'h10, 8'h01, 1'b0, "R2 plain");
    testGood(8'h00, 5, 8'h30, 8'h00, 1'b1, "R8 concat");
    testGood(8'h00, 0, 8'h00, 8'h01, 1'b0, "R3 empty payload");
    testGood(8'h42, 3, 8'hC0, 8'h01, 1'b0, "R2 other header");
    testDrop(8'h01, 6, 1'b1, "R6 idle");
    testDrop(8'h80, 6, 1'b0, "R7 bad plain");
    testDrop(8'h80, 2, 1'b1, "R7 bad concat");
    testGap();
    testBackToBack();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=finished", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule